// File: doc/BRIEF.md
# BF16 Iterative Square Root

This block takes one bfloat16 operand (1 sign bit, 8 exponent bits with bias 127, 7 fraction bits) and returns its square root as a bfloat16 word. A one-cycle start pulse launches an operation. A one-cycle done pulse marks the cycle in which the result is valid. The result register keeps that value until the next operation completes.

Operands that need no arithmetic are resolved in one cycle. These are NaN, infinities, zeros, subnormals and negative values. A positive normal operand goes through four steps. The exponent is halved. A 9-bit working mantissa is formed. The largest integer root of that mantissa is found by a bounded binary search, with one 9x9 integer square per step. The root is then normalised and packed with the fraction truncated. A parameter selects the squarer: a single-cycle combinational product, or a shift-add unit that takes several cycles per step. Both give identical results.

Top module: `bfsqrt_unit`

## Requirements
- R1: An operand with exponent field 0xFF and a nonzero fraction (NaN) is returned unchanged, bit for bit, sign included.
- R2: Operand 0x7F80 (+infinity) gives 0x7F80; operand 0xFF80 (-infinity) gives the canonical NaN 0x7FC0.
- R3: An operand with exponent field 0 gives 0x0000 when it is +0, -0 or a positive subnormal. Any negative operand that is not -0, not NaN and not -infinity gives 0x7FC0.
- R4: Every operand covered by R1 to R3 completes without a search: if start is sampled at clock edge k, done is high and result is valid after edge k+1.
- R5: For a positive normal operand with exponent field e, the result exponent field is floor((e-127)/2)+127. The working mantissa is 0x80 OR fraction, and it is doubled when e-127 is odd.
- R6: The root is the largest integer r in [90, 256] with floor(r*r/128) not above the working mantissa. It is found by a binary search that starts from low 90, high 256 and root 128. The result fraction is r AND 0x7F. Reference values: 0x4080 gives 0x4000, 0x41C8 gives 0x40A0, 0x4000 gives 0x3FB5.
- R7: Every non-NaN result has sign bit 0. A root of 256 or more is halved with the exponent raised by one. A root below 128 is doubled while the exponent stays above 1. A packed exponent of 255 or more gives 0x7F80, and one of 0 or less gives 0x0000.
- R8: After reset, result is 0x0000 and done is low. Done is high for exactly one cycle per accepted operation. Result changes only at the edge that raises done.
- R9: A start pulse that arrives while a search is running is ignored: its operand is not used and no additional done pulse follows.
- R10: A start pulse in the same cycle as done is accepted as a new operation.
- R11: The combinational squarer and the shift-add squarer, chosen by parameter SEQ_MUL, produce identical results for every operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin an operation on operand |
| operand | input | 16 | bfloat16 input value |
| result | output | 16 | bfloat16 square root, held between operations |
| done | output | 1 | One-cycle pulse: result holds the value of the last accepted operation |

## Verification
The completion of one operation and the acceptance of the next can fall in the same cycle. The search returns to idle on the same edge that raises done, so a start seen in the done cycle is taken. To provoke this, the bench waits for done on a normal operand and drives start with a special operand in that same cycle. It judges the outcome from two observations: the first result is valid in the done cycle, and the special result appears one cycle later with done high again. A start pulse in the middle of a search is also tried. The bench checks that it leaves the result and the done count untouched.

// File: rtl/bfsqrt_pkg.sv
package bfsqrt_pkg;

  localparam int unsigned DEF_EXP_W     = 8;
  localparam int unsigned DEF_FRAC_W    = 7;
  localparam int unsigned DEF_SEARCH_LO = 90;

  typedef enum logic {
    SRCH_IDLE = 1'b0,
    SRCH_RUN  = 1'b1
  } srch_st_e;

  typedef enum logic {
    MUL_IDLE = 1'b0,
    MUL_RUN  = 1'b1
  } mul_st_e;

endpackage

// File: rtl/bfsqrt_classify.sv
module bfsqrt_classify
  import bfsqrt_pkg::*;
#(
  parameter int unsigned EXP_W  = DEF_EXP_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W
) (
  input  logic [EXP_W+FRAC_W:0]       opnd,
  output logic                        is_special,
  output logic [EXP_W+FRAC_W:0]       special_val,
  output logic [FRAC_W+1:0]           work_mant,
  output logic signed [EXP_W+1:0]     half_exp
);

  localparam int unsigned W    = 1 + EXP_W + FRAC_W;
  localparam int unsigned EXW  = EXP_W + 2;
  localparam int unsigned BIAS = (1 << (EXP_W - 1)) - 1;

  localparam logic [W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic              ex_ones;
  logic              ex_zero;
  logic              fr_zero;
  logic signed [EXW-1:0] ue;

  assign sgn     = opnd[W-1];
  assign ex      = opnd[W-2:FRAC_W];
  assign fr      = opnd[FRAC_W-1:0];
  assign ex_ones = &ex;
  assign ex_zero = ~|ex;
  assign fr_zero = ~|fr;

  always_comb begin
    is_special  = 1'b1;
    special_val = '0;
    if (ex_ones) begin
      if (!fr_zero) begin
        special_val = opnd;
      end else if (sgn) begin
        special_val = QNAN;
      end else begin
        special_val = opnd;
      end
    end else if (ex_zero && fr_zero) begin
      special_val = '0;
    end else if (sgn) begin
      special_val = QNAN;
    end else if (ex_zero) begin
      special_val = '0;
    end else begin
      is_special  = 1'b0;
    end
  end

  always_comb begin
    ue       = $signed({2'b00, ex}) - $signed(EXW'(BIAS));
    half_exp = (ue >>> 1) + $signed(EXW'(BIAS));
    if (ue[0]) begin
      work_mant = {1'b1, fr, 1'b0};
    end else begin
      work_mant = {1'b0, 1'b1, fr};
    end
  end

endmodule

// File: rtl/bfsqrt_mul_seq.sv
module bfsqrt_mul_seq
  import bfsqrt_pkg::*;
#(
  parameter int unsigned OP_W = DEF_FRAC_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [OP_W-1:0]   op,
  output logic              rdy,
  output logic [2*OP_W-1:0] prod
);

  localparam int unsigned PW = 2 * OP_W;
  localparam int unsigned CW = $clog2(OP_W + 1);

  mul_st_e         mst_q, mst_d;
  logic [PW-1:0]   acc_q, acc_d;
  logic [PW-1:0]   mcand_q, mcand_d;
  logic [OP_W-1:0] mplier_q, mplier_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            reg_en;

  always_comb begin
    mst_d    = mst_q;
    acc_d    = acc_q;
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    cnt_d    = cnt_q;
    rdy      = 1'b0;
    reg_en   = 1'b0;
    case (mst_q)
      MUL_IDLE: begin
        if (go) begin
          reg_en   = 1'b1;
          mst_d    = MUL_RUN;
          acc_d    = '0;
          mcand_d  = {{OP_W{1'b0}}, op};
          mplier_d = op;
          cnt_d    = CW'(OP_W);
        end
      end
      default: begin
        reg_en = 1'b1;
        if (cnt_q != '0) begin
          if (mplier_q[0]) begin
            acc_d = acc_q + mcand_q;
          end
          mcand_d  = mcand_q << 1;
          mplier_d = mplier_q >> 1;
          cnt_d    = cnt_q - CW'(1);
        end else begin
          rdy   = 1'b1;
          mst_d = MUL_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q    <= MUL_IDLE;
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
    end else if (reg_en) begin
      mst_q    <= mst_d;
      acc_q    <= acc_d;
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      cnt_q    <= cnt_d;
    end
  end

  assign prod = acc_q;

endmodule

// File: rtl/bfsqrt_search.sv
module bfsqrt_search
  import bfsqrt_pkg::*;
#(
  parameter int unsigned FRAC_W    = DEF_FRAC_W,
  parameter int unsigned SEARCH_LO = DEF_SEARCH_LO,
  parameter bit          SEQ_MUL   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FRAC_W+1:0] mant,
  output logic              busy,
  output logic              fin,
  output logic [FRAC_W+1:0] root
);

  localparam int unsigned RW = FRAC_W + 2;
  localparam int unsigned BW = RW + 1;
  localparam int unsigned PW = 2 * RW;

  localparam logic [BW-1:0] LO_INIT  = BW'(SEARCH_LO);
  localparam logic [BW-1:0] HI_INIT  = BW'(1 << (FRAC_W + 1));
  localparam logic [RW-1:0] RES_INIT = RW'(1 << FRAC_W);

  srch_st_e      st_q, st_d;
  logic [BW-1:0] lo_q, lo_d;
  logic [BW-1:0] hi_q, hi_d;
  logic [RW-1:0] res_q, res_d;
  logic [RW-1:0] mm_q, mm_d;
  logic          reg_en;

  logic [BW-1:0] mid;
  logic [RW-1:0] mul_op;
  logic          mul_go;
  logic          mul_rdy;
  logic [PW-1:0] mul_prod;
  logic          fits;

  assign mid    = (lo_q + hi_q) >> 1;
  assign mul_op = mid[RW-1:0];
  assign fits   = (mul_prod >> FRAC_W) <= {{RW{1'b0}}, mm_q};

  generate
    if (SEQ_MUL) begin : g_seq
      bfsqrt_mul_seq #(.OP_W(RW)) i_mul (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (mul_go),
        .op   (mul_op),
        .rdy  (mul_rdy),
        .prod (mul_prod)
      );
    end else begin : g_comb
      assign mul_prod = {{RW{1'b0}}, mul_op} * {{RW{1'b0}}, mul_op};
      assign mul_rdy  = mul_go;
    end
  endgenerate

  always_comb begin
    st_d   = st_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    res_d  = res_q;
    mm_d   = mm_q;
    fin    = 1'b0;
    mul_go = 1'b0;
    reg_en = 1'b0;
    case (st_q)
      SRCH_IDLE: begin
        if (load) begin
          reg_en = 1'b1;
          st_d   = SRCH_RUN;
          lo_d   = LO_INIT;
          hi_d   = HI_INIT;
          res_d  = RES_INIT;
          mm_d   = mant;
        end
      end
      default: begin
        if (lo_q <= hi_q) begin
          mul_go = 1'b1;
          if (mul_rdy) begin
            reg_en = 1'b1;
            if (fits) begin
              res_d = mul_op;
              lo_d  = mid + BW'(1);
            end else begin
              hi_d  = mid - BW'(1);
            end
          end
        end else begin
          reg_en = 1'b1;
          fin    = 1'b1;
          st_d   = SRCH_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SRCH_IDLE;
      lo_q  <= '0;
      hi_q  <= '0;
      res_q <= '0;
      mm_q  <= '0;
    end else if (reg_en) begin
      st_q  <= st_d;
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      res_q <= res_d;
      mm_q  <= mm_d;
    end
  end

  assign busy = (st_q == SRCH_RUN);
  assign root = res_q;

endmodule

// File: rtl/bfsqrt_pack.sv
module bfsqrt_pack
  import bfsqrt_pkg::*;
#(
  parameter int unsigned EXP_W  = DEF_EXP_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W
) (
  input  logic [FRAC_W+1:0]       root,
  input  logic signed [EXP_W+1:0] nexp,
  output logic [EXP_W+FRAC_W:0]   word
);

  localparam int unsigned W       = 1 + EXP_W + FRAC_W;
  localparam int unsigned RW      = FRAC_W + 2;
  localparam int unsigned EXW     = EXP_W + 2;
  localparam int unsigned EXP_MAX = (1 << EXP_W) - 1;

  localparam logic [W-1:0] PINF = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic [RW-1:0]          r;
  logic signed [EXW-1:0]  e;

  always_comb begin
    r = root;
    e = nexp;
    if (r[RW-1]) begin
      r = r >> 1;
      e = e + $signed(EXW'(1));
    end else begin
      for (int i = 0; i < FRAC_W + 1; i++) begin
        if (!r[FRAC_W] && (e > $signed(EXW'(1)))) begin
          r = r << 1;
          e = e - $signed(EXW'(1));
        end
      end
    end
    if (e >= $signed(EXW'(EXP_MAX))) begin
      word = PINF;
    end else if (e <= $signed(EXW'(0))) begin
      word = '0;
    end else begin
      word = {1'b0, e[EXP_W-1:0], r[FRAC_W-1:0]};
    end
  end

endmodule

// File: rtl/bfsqrt_unit.sv
module bfsqrt_unit
  import bfsqrt_pkg::*;
#(
  parameter int unsigned EXP_W     = DEF_EXP_W,
  parameter int unsigned FRAC_W    = DEF_FRAC_W,
  parameter int unsigned SEARCH_LO = DEF_SEARCH_LO,
  parameter bit          SEQ_MUL   = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [EXP_W+FRAC_W:0]   operand,
  output logic [EXP_W+FRAC_W:0]   result,
  output logic                    done
);

  localparam int unsigned W   = 1 + EXP_W + FRAC_W;
  localparam int unsigned RW  = FRAC_W + 2;
  localparam int unsigned EXW = EXP_W + 2;

  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rsync_q[1];

  logic                  spec;
  logic [W-1:0]          spec_val;
  logic [RW-1:0]         wmant;
  logic signed [EXW-1:0] hexp;

  bfsqrt_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_classify (
    .opnd       (operand),
    .is_special (spec),
    .special_val(spec_val),
    .work_mant  (wmant),
    .half_exp   (hexp)
  );

  logic          s_busy;
  logic          s_fin;
  logic          s_load;
  logic [RW-1:0] s_root;
  logic          accept;

  assign accept = start && !s_busy;
  assign s_load = accept && !spec;

  bfsqrt_search #(
    .FRAC_W   (FRAC_W),
    .SEARCH_LO(SEARCH_LO),
    .SEQ_MUL  (SEQ_MUL)
  ) i_search (
    .clk  (clk),
    .rst_n(rst_core_n),
    .load (s_load),
    .mant (wmant),
    .busy (s_busy),
    .fin  (s_fin),
    .root (s_root)
  );

  logic signed [EXW-1:0] nexp_q;
  logic [W-1:0]          packed_w;

  bfsqrt_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_pack (
    .root(s_root),
    .nexp(nexp_q),
    .word(packed_w)
  );

  logic [W-1:0] out_q, out_d;
  logic         done_q, done_d;
  logic         out_en;

  always_comb begin
    out_d  = out_q;
    done_d = 1'b0;
    out_en = 1'b0;
    if (accept && spec) begin
      out_d  = spec_val;
      done_d = 1'b1;
      out_en = 1'b1;
    end else if (s_fin) begin
      out_d  = packed_w;
      done_d = 1'b1;
      out_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      out_q  <= '0;
      done_q <= 1'b0;
      nexp_q <= '0;
    end else begin
      done_q <= done_d;
      if (out_en) begin
        out_q <= out_d;
      end
      if (s_load) begin
        nexp_q <= hexp;
      end
    end
  end

  assign result = out_q;
  assign done   = done_q;

endmodule

// File: rtl/bfsqrt_unit_chk.sv
module bfsqrt_unit_chk
  import bfsqrt_pkg::*;
#(
  parameter int unsigned EXP_W  = DEF_EXP_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W
) (
  input logic                  clk,
  input logic                  rst_core_n,
  input logic                  start,
  input logic [EXP_W+FRAC_W:0] operand,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  done,
  input logic                  busy
);

  localparam int unsigned W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic in_ones, in_zero, in_nan, in_sgn, in_mag;
  logic out_nan;

  assign in_ones = &operand[W-2:FRAC_W];
  assign in_zero = ~|operand[W-2:FRAC_W];
  assign in_nan  = in_ones && |operand[FRAC_W-1:0];
  assign in_sgn  = operand[W-1];
  assign in_mag  = |operand[W-2:0];
  assign out_nan = &result[W-2:FRAC_W] && |result[FRAC_W-1:0];

  AST_NAN_PASS: assert property (@(posedge clk) disable iff (!rst_core_n)
    start && !busy && in_nan |=> done && (result == $past(operand))); // R1

  AST_NEG_NAN: assert property (@(posedge clk) disable iff (!rst_core_n)
    start && !busy && in_sgn && in_mag && !in_nan |=> result == QNAN); // R3

  AST_SPECIAL_LAT: assert property (@(posedge clk) disable iff (!rst_core_n)
    start && !busy && (in_ones || in_zero || in_sgn) |=> done); // R4

  AST_POS_SIGN: assert property (@(posedge clk) disable iff (!rst_core_n)
    done && !out_nan |-> !result[W-1]); // R7

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_core_n)
    done && !start |=> !done); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    !done |-> $stable(result)); // R8

  AST_NO_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_core_n)
    busy |-> !done); // R9

endmodule

bind bfsqrt_unit bfsqrt_unit_chk i_bfsqrt_unit_chk (
  .clk       (clk),
  .rst_core_n(rst_core_n),
  .start     (start),
  .operand   (operand),
  .result    (result),
  .done      (done),
  .busy      (s_busy)
);

// File: tb/test_bfsqrt_unit.sv
module test_bfsqrt_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT_MAX   = 2000;
  localparam int WDOG_CYC   = 150000;

  logic        clk;
  logic        rst_n;
  logic        start_s [2];
  logic [15:0] opnd    [2];
  logic [15:0] res     [2];
  logic        dn      [2];

  int total;
  int bad;
  int dcnt [2];

  bfsqrt_unit i_bfsqrt_unit (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_s[0]),
    .operand(opnd[0]),
    .result (res[0]),
    .done   (dn[0])
  );

  bfsqrt_unit #(.SEQ_MUL(1'b1)) i_bfsqrt_unit_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_s[1]),
    .operand(opnd[1]),
    .result (res[1]),
    .done   (dn[1])
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) if (dn[0]) dcnt[0] <= dcnt[0] + 1;
  always @(posedge clk) if (dn[1]) dcnt[1] <= dcnt[1] + 1;

  function automatic logic [15:0] ref_sqrt(input logic [15:0] a);
    int e, f, ue, ne, mm, r;
    e = int'(a[14:7]);
    f = int'(a[6:0]);
    if (e == 255) return (f != 0) ? a : (a[15] ? 16'h7FC0 : a);
    if (e == 0 && f == 0) return 16'h0000;
    if (a[15]) return 16'h7FC0;
    if (e == 0) return 16'h0000;
    ue = e - 127;
    mm = 128 + f;
    if (ue % 2 != 0) mm = mm * 2;
    ne = (ue >= 0) ? ue / 2 : -((1 - ue) / 2);
    ne = ne + 127;
    r = 0;
    for (int k = 90; k <= 256; k++) begin
      if ((k * k) / 128 <= mm) r = k;
    end
    if (r >= 256) begin
      r = r / 2;
      ne = ne + 1;
    end
    while (r < 128 && ne > 1) begin
      r = r * 2;
      ne = ne - 1;
    end
    if (ne >= 255) return 16'h7F80;
    if (ne <= 0) return 16'h0000;
    return 16'((ne << 7) | (r & 127));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic launch(input int sel, input logic [15:0] a);
    opnd[sel]    = a;
    start_s[sel] = 1'b1;
    @(negedge clk);
    start_s[sel] = 1'b0;
  endtask

  task automatic wait_done(input int sel, output bit seen);
    seen = dn[sel];
    for (int i = 0; i < WAIT_MAX && !seen; i++) begin
      @(negedge clk);
      seen = dn[sel];
    end
  endtask

  task automatic t_reset();
    for (int s = 0; s < 2; s++) begin
      chk(res[s] == 16'h0000, "R8 reset result", res[s], 16'h0000);
      chk(dn[s] == 1'b0, "R8 reset done", {15'b0, dn[s]}, 16'h0000);
    end
  endtask

  task automatic t_special(input int sel, input logic [15:0] a, input string tag);
    logic [15:0] ex;
    ex = ref_sqrt(a);
    launch(sel, a);
    chk(dn[sel] == 1'b1, "R4 special done one cycle after start", {15'b0, dn[sel]}, 16'h0001);
    chk(res[sel] == ex, tag, res[sel], ex);
    @(negedge clk);
    chk(dn[sel] == 1'b0, "R8 special done pulse width", {15'b0, dn[sel]}, 16'h0000);
  endtask

  task automatic t_specials(input int sel);
    t_special(sel, 16'h7FC1, "R1 positive NaN passes");
    t_special(sel, 16'hFFA5, "R1 negative NaN passes");
    t_special(sel, 16'h7F80, "R2 plus infinity");
    t_special(sel, 16'hFF80, "R2 minus infinity to NaN");
    t_special(sel, 16'h0000, "R3 plus zero");
    t_special(sel, 16'h8000, "R3 minus zero to plus zero");
    t_special(sel, 16'h0005, "R3 positive subnormal to zero");
    t_special(sel, 16'h8003, "R3 negative subnormal to NaN");
    t_special(sel, 16'hC080, "R3 negative normal to NaN");
  endtask

  task automatic t_normal(input int sel, input logic [15:0] a, input logic [15:0] ex,
                          input string tag);
    bit          seen;
    logic [15:0] held;
    launch(sel, a);
    wait_done(sel, seen);
    chk(seen, "R8 done seen for normal operand", {15'b0, seen}, 16'h0001);
    chk(res[sel] == ex, tag, res[sel], ex);
    chk(res[sel][15] == 1'b0, "R7 sign of normal result", res[sel], ex);
    held = res[sel];
    @(negedge clk);
    chk(dn[sel] == 1'b0, "R8 done pulse width", {15'b0, dn[sel]}, 16'h0000);
    repeat (3) @(negedge clk);
    chk(res[sel] == held, "R8 result held", res[sel], held);
  endtask

  task automatic t_refs(input int sel);
    t_normal(sel, 16'h4080, 16'h4000, sel == 1 ? "R11 R6 sqrt 4.0" : "R6 sqrt 4.0");
    t_normal(sel, 16'h41C8, 16'h40A0, sel == 1 ? "R11 R6 sqrt 25.0" : "R6 sqrt 25.0");
    t_normal(sel, 16'h4000, 16'h3FB5, sel == 1 ? "R11 R6 sqrt 2.0" : "R6 sqrt 2.0");
  endtask

  task automatic t_sweep(input int sel);
    logic [15:0] ops [8];
    ops[0] = 16'h3F80; ops[1] = 16'h3F00; ops[2] = 16'h0080; ops[3] = 16'h7F7F;
    ops[4] = 16'h4049; ops[5] = 16'h3E4C; ops[6] = 16'h42C8; ops[7] = 16'h00FF;
    for (int i = 0; i < 8; i++) begin
      t_normal(sel, ops[i], ref_sqrt(ops[i]),
               sel == 1 ? "R11 R5 R6 sweep" : "R5 R6 sweep");
    end
  endtask

  task automatic t_busy(input int sel);
    bit          seen;
    int          c0;
    logic [15:0] ex;
    ex = ref_sqrt(16'h4110);
    c0 = dcnt[sel];
    launch(sel, 16'h4110);
    @(negedge clk);
    opnd[sel]    = 16'h7F80;
    start_s[sel] = 1'b1;
    @(negedge clk);
    start_s[sel] = 1'b0;
    chk(dn[sel] == 1'b0, "R9 start while busy gives no done", {15'b0, dn[sel]}, 16'h0000);
    wait_done(sel, seen);
    chk(seen, "R9 first operation completes", {15'b0, seen}, 16'h0001);
    chk(res[sel] == ex, "R9 result from first operand", res[sel], ex);
    @(negedge clk);
    chk(dcnt[sel] - c0 == 1, "R9 exactly one done pulse", 16'(dcnt[sel] - c0), 16'h0001);
  endtask

  task automatic t_b2b(input int sel);
    bit          seen;
    logic [15:0] ex;
    ex = ref_sqrt(16'h4348);
    launch(sel, 16'h4348);
    wait_done(sel, seen);
    chk(seen && res[sel] == ex, "R10 first result in done cycle", res[sel], ex);
    opnd[sel]    = 16'hFF80;
    start_s[sel] = 1'b1;
    @(negedge clk);
    start_s[sel] = 1'b0;
    chk(dn[sel] == 1'b1, "R10 start in done cycle accepted", {15'b0, dn[sel]}, 16'h0001);
    chk(res[sel] == 16'h7FC0, "R10 second result", res[sel], 16'h7FC0);
    @(negedge clk);
    chk(dn[sel] == 1'b0, "R8 done drops after back to back", {15'b0, dn[sel]}, 16'h0000);
  endtask

  initial begin
    total = 0;
    bad   = 0;
    dcnt[0] = 0;
    dcnt[1] = 0;
    rst_n = 1'b0;
    for (int s = 0; s < 2; s++) begin
      start_s[s] = 1'b0;
      opnd[s]    = 16'h0000;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    for (int s = 0; s < 2; s++) begin
      t_specials(s);
      t_refs(s);
      t_sweep(s);
      t_busy(s);
      t_b2b(s);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", WDOG_CYC);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule